// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into bytes. A strobe that pulses sixteen times per bit period paces it. The serial input passes through a two-flop synchronizer. A state machine then hunts for a falling edge, confirms the start bit at its midpoint, and samples each later bit in the middle of its period. The frame is set by four line-control inputs: word length, parity enable, even select and stick parity.

Each finished character goes into a single holding buffer and raises a data-ready flag. The block also keeps sticky flags for overrun, parity error, framing error and line break. The surrounding bus logic pulses `rd_data` when software takes the byte, which clears data-ready. It pulses `rd_status` when software reads the line status, which clears the four error flags.

The state machine has six states:
- HUNT: the line is idle. A low sample on a tick moves to START.
- START: on the eighth tick, a high line returns to HUNT (a false start). A low line moves to DATA.
- DATA: takes one bit every sixteen ticks. After the last bit of the word it moves to PARITY if parity is enabled, otherwise to STOP.
- PARITY: samples the parity bit, then moves to STOP.
- STOP: samples the stop bit and delivers the character. It then moves to BRKWAIT if the whole frame was low, otherwise back to HUNT.
- BRKWAIT: holds until the line is high again, then returns to HUNT.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `data_ready` is 0, `rx_data` is 0x00, and the four error flags are 0.
- R2: Data bits are taken least significant bit first, at the sixteenth tick of each bit period. `cfg_word_len` selects 5 + value data bits (0=5, 1=6, 2=7, 3=8), and unused upper bits of `rx_data` read 0.
- R3: When a character completes, `rx_data` takes it and `data_ready` goes to 1 on the next clock. A one-cycle `rd_data` pulse clears `data_ready`.
- R4: The start bit is checked on the eighth tick after it is detected. If the line is high there, the block returns to hunting and nothing is stored.
- R5: With `cfg_parity_en`=1 and `cfg_stick`=0, one parity bit follows the data. `cfg_even_sel`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `err_parity`.
- R6: With `cfg_parity_en`=1 and `cfg_stick`=1, the parity bit must equal the inverse of `cfg_even_sel`. Anything else sets `err_parity`.
- R7: A stop bit sampled low sets `err_framing`, and the character is still delivered. The receiver then accepts the next correct frame normally.
- R8: A frame that is low in every bit, stop bit included, sets `err_break` and `err_framing`, stores 0x00 and raises `data_ready` once. No further character is accepted until the line has returned high.
- R9: If a character completes while `data_ready` is still 1 and no `rd_data` arrives in that cycle, `err_overrun` is set and the buffer takes the new character.
- R10: A `rd_status` pulse clears `err_overrun`, `err_parity`, `err_framing` and `err_break` on the next clock, unless a character completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| cfg_word_len | input | 2 | Data bits minus five |
| cfg_parity_en | input | 1 | A parity bit follows the data |
| cfg_even_sel | input | 1 | Selects even parity (1) or odd parity (0) |
| cfg_stick | input | 1 | Parity bit is fixed to the inverse of even select |
| rd_data | input | 1 | Pulse: buffer consumed, clears data ready |
| rd_status | input | 1 | Pulse: status consumed, clears error flags |
| rx_data | output | 8 | Last received character |
| data_ready | output | 1 | Buffer holds an unread character |
| err_overrun | output | 1 | A character replaced an unread one |
| err_parity | output | 1 | Parity mismatch seen |
| err_framing | output | 1 | Stop bit sampled low |
| err_break | output | 1 | Whole-frame low line detected |

## Verification
The main path is driven with alternating and asymmetric byte values at several word lengths. A misordered shift or a wrong bit-count terminator shows up as a different byte, and stray upper bits show up as nonzero high bits in `rx_data`. Parity is tried in even, odd and both stick settings, each with a correct bit and with a corrupted bit, so that an inverted sense is separated from a missing check. Short low glitches, a frame with a low stop bit followed by a clean frame, a long low line, and two frames sent without a read test the false-start, resynchronization, break-hold and overrun paths against one another.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       even_sel,
    input  logic       stick,
    output logic       done,
    output rx_char_t   chr
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       bidx_q;
    logic [7:0]       shreg_q;
    logic             zero_q, par_q;
    logic             sample;
    logic             last_bit;

    assign sample   = tick && (state_q == ST_START ? cnt_q == MID : cnt_q == LAST);
    assign last_bit = (bidx_q == {1'b1, word_len});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (tick && !line) state_d = ST_START;
            ST_START:   if (sample) state_d = line ? ST_HUNT : ST_DATA;
            ST_DATA:    if (sample && last_bit) state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:  if (sample) state_d = ST_STOP;
            ST_STOP:    if (sample) state_d = (zero_q && !line) ? ST_BRKWAIT : ST_HUNT;
            ST_BRKWAIT: if (line) state_d = ST_HUNT;
            default:    state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            zero_q  <= 1'b1;
            par_q   <= 1'b0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (tick)          cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_START && state_d == ST_DATA) begin
                shreg_q <= '0;
                bidx_q  <= '0;
                zero_q  <= 1'b1;
            end else if (sample && state_q == ST_DATA) begin
                shreg_q[bidx_q] <= line;
                bidx_q          <= bidx_q + 1'b1;
                zero_q          <= zero_q & ~line;
            end else if (sample && state_q == ST_PARITY) begin
                par_q  <= line;
                zero_q <= zero_q & ~line;
            end
        end
    end

    always_comb begin
        done     = sample && (state_q == ST_STOP);
        chr.data = shreg_q;
        chr.ferr = !line;
        chr.brk  = zero_q && !line;
        if (!par_en)    chr.perr = 1'b0;
        else if (stick) chr.perr = (par_q == even_sel);
        else            chr.perr = (^shreg_q) ^ par_q ^ ~even_sel;
    end

    // R4
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && sample && line) |=> !done && state_q == ST_HUNT);
    // R8
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRKWAIT && !line) |=> !done);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  rx_char_t   chr,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_data,
    output logic       data_ready,
    output logic       err_overrun,
    output logic       err_parity,
    output logic       err_framing,
    output logic       err_break
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            data_ready  <= 1'b0;
            err_overrun <= 1'b0;
            err_parity  <= 1'b0;
            err_framing <= 1'b0;
            err_break   <= 1'b0;
        end else begin
            if (rd_status) begin
                err_overrun <= 1'b0;
                err_parity  <= 1'b0;
                err_framing <= 1'b0;
                err_break   <= 1'b0;
            end
            if (rd_data) data_ready <= 1'b0;
            if (done) begin
                rx_data    <= chr.data;
                data_ready <= 1'b1;
                if (data_ready && !rd_data) err_overrun <= 1'b1;
                if (chr.perr) err_parity  <= 1'b1;
                if (chr.ferr) err_framing <= 1'b1;
                if (chr.brk)  err_break   <= 1'b1;
            end
        end
    end

    // R3
    dr_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> data_ready);
    // R3
    dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !data_ready);
    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && data_ready && !rd_data) |=> err_overrun);
    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !done) |=> !(err_overrun || err_parity || err_framing || err_break));
    // R8
    break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_break) |-> data_ready && rx_data == 8'h00);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       serial_in,
    input  logic [1:0] cfg_word_len,
    input  logic       cfg_parity_en,
    input  logic       cfg_even_sel,
    input  logic       cfg_stick,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_data,
    output logic       data_ready,
    output logic       err_overrun,
    output logic       err_parity,
    output logic       err_framing,
    output logic       err_break
);
    logic     line_s;
    logic     chr_done;
    rx_char_t chr;

    uart_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (serial_in),
        .dout (line_s)
    );

    uart_rx_framer #(.OSR(OSR)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .line    (line_s),
        .word_len(cfg_word_len),
        .par_en  (cfg_parity_en),
        .even_sel(cfg_even_sel),
        .stick   (cfg_stick),
        .done    (chr_done),
        .chr     (chr)
    );

    uart_rx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (chr_done),
        .chr        (chr),
        .rd_data    (rd_data),
        .rd_status  (rd_status),
        .rx_data    (rx_data),
        .data_ready (data_ready),
        .err_overrun(err_overrun),
        .err_parity (err_parity),
        .err_framing(err_framing),
        .err_break  (err_break)
    );
endmodule

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
    localparam int TDIV = 4;
    localparam int BITCLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       serial_in = 1'b1;
    logic [1:0] cfg_word_len = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_even_sel = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, err_overrun, err_parity, err_framing, err_break;
    int         checks = 0;
    int         failures = 0;
    int         tdiv_cnt = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        tick16   <= (tdiv_cnt == TDIV - 1);
    end

    uart_rx_core uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .serial_in(serial_in),
        .cfg_word_len(cfg_word_len), .cfg_parity_en(cfg_parity_en),
        .cfg_even_sel(cfg_even_sel), .cfg_stick(cfg_stick),
        .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
        .data_ready(data_ready), .err_overrun(err_overrun), .err_parity(err_parity),
        .err_framing(err_framing), .err_break(err_break)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line_for(input logic v, input int bits);
        serial_in = v;
        repeat (bits * BITCLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic pbit, input logic stopv);
        int nb;
        nb = 5 + int'(cfg_word_len);
        line_for(1'b0, 1);
        for (int i = 0; i < nb; i++) line_for(d[i], 1);
        if (cfg_parity_en) line_for(pbit, 1);
        line_for(stopv, 1);
        line_for(1'b1, 1);
    endtask

    task automatic pulse_rd_data();
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
    endtask

    task automatic pulse_rd_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
    endtask

    task automatic flags(input string req, input int ov, input int pe, input int fe, input int bi);
        check({req, " overrun"}, err_overrun, ov);
        check({req, " parity"}, err_parity, pe);
        check({req, " framing"}, err_framing, fe);
        check({req, " break"}, err_break, bi);
    endtask

    task automatic t_reset();
        check("R1 data_ready", data_ready, 0);
        check("R1 rx_data", rx_data, 0);
        flags("R1", 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        cfg_word_len = 2'd3; cfg_parity_en = 1'b0;
        send(8'hA5, 1'b0, 1'b1);
        check("R2 byte A5", rx_data, 8'hA5);
        check("R3 ready set", data_ready, 1);
        flags("R2", 0, 0, 0, 0);
        pulse_rd_data();
        check("R3 ready cleared", data_ready, 0);
        send(8'h3C, 1'b0, 1'b1);
        check("R2 byte 3C", rx_data, 8'h3C);
        pulse_rd_data();
        cfg_word_len = 2'd0;
        send(8'hF3, 1'b0, 1'b1);
        check("R2 5-bit word", rx_data, 8'h13);
        pulse_rd_data();
        cfg_word_len = 2'd2;
        send(8'hC1, 1'b0, 1'b1);
        check("R2 7-bit word", rx_data, 8'h41);
        pulse_rd_data();
        cfg_word_len = 2'd3;
    endtask

    task automatic t_false_start();
        serial_in = 1'b0;
        repeat (12) @(negedge clk);
        line_for(1'b1, 3);
        check("R4 no ready after glitch", data_ready, 0);
        check("R4 buffer unchanged", rx_data, 8'h41);
        send(8'h96, 1'b0, 1'b1);
        check("R4 next frame ok", rx_data, 8'h96);
        pulse_rd_data();
    endtask

    task automatic t_parity();
        cfg_parity_en = 1'b1; cfg_stick = 1'b0;
        cfg_even_sel = 1'b1;
        send(8'h07, 1'b1, 1'b1);
        check("R5 even good", err_parity, 0);
        send(8'h07, 1'b0, 1'b1);
        check("R5 even bad", err_parity, 1);
        pulse_rd_status(); pulse_rd_data();
        cfg_even_sel = 1'b0;
        send(8'h07, 1'b0, 1'b1);
        check("R5 odd good", err_parity, 0);
        check("R5 data with parity", rx_data, 8'h07);
        send(8'h07, 1'b1, 1'b1);
        check("R5 odd bad", err_parity, 1);
        pulse_rd_status(); pulse_rd_data();
        cfg_stick = 1'b1; cfg_even_sel = 1'b0;
        send(8'h00, 1'b1, 1'b1);
        check("R6 stick one good", err_parity, 0);
        send(8'h00, 1'b0, 1'b1);
        check("R6 stick one bad", err_parity, 1);
        pulse_rd_status(); pulse_rd_data();
        cfg_even_sel = 1'b1;
        send(8'hFF, 1'b0, 1'b1);
        check("R6 stick zero good", err_parity, 0);
        send(8'hFF, 1'b1, 1'b1);
        check("R6 stick zero bad", err_parity, 1);
        pulse_rd_status(); pulse_rd_data();
        cfg_parity_en = 1'b0; cfg_stick = 1'b0;
    endtask

    task automatic t_framing();
        send(8'h55, 1'b0, 1'b0);
        check("R7 data kept", rx_data, 8'h55);
        flags("R7 bad stop", 0, 0, 1, 0);
        pulse_rd_data();
        send(8'h3A, 1'b0, 1'b1);
        check("R7 resync data", rx_data, 8'h3A);
        check("R7 flag sticky", err_framing, 1);
        pulse_rd_status();
        flags("R10 cleared", 0, 0, 0, 0);
        pulse_rd_data();
    endtask

    task automatic t_break();
        line_for(1'b0, 11);
        check("R8 zero char", rx_data, 0);
        check("R8 ready", data_ready, 1);
        flags("R8 break", 0, 0, 1, 1);
        pulse_rd_data();
        line_for(1'b0, 12);
        check("R8 no second char", data_ready, 0);
        line_for(1'b1, 2);
        check("R8 still none", data_ready, 0);
        send(8'h81, 1'b0, 1'b1);
        check("R8 after release", rx_data, 8'h81);
        pulse_rd_status();
        flags("R10 after break", 0, 0, 0, 0);
        pulse_rd_data();
    endtask

    task automatic t_overrun();
        send(8'h11, 1'b0, 1'b1);
        check("R9 first no overrun", err_overrun, 0);
        send(8'h22, 1'b0, 1'b1);
        check("R9 overrun set", err_overrun, 1);
        check("R9 newest kept", rx_data, 8'h22);
        pulse_rd_status();
        check("R10 overrun cleared", err_overrun, 0);
        check("R10 ready untouched", data_ready, 1);
        pulse_rd_data();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_basic();
        t_false_start();
        t_parity();
        t_framing();
        t_break();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule